// File: doc/BRIEF.md
# Dual-Mode Cache SRAM Strobe Controller

This block drives the single strobe line of a secondary-cache data SRAM array. A static mode pin selects one of two meanings for that line. With synchronous burst SRAMs, a high strobe makes the SRAMs capture the address now on the bus. A low strobe lets them step through addresses with their own internal burst counter. With asynchronous SRAMs, the line drives an external transparent address latch. A high strobe keeps the latch open, and dropping it freezes the address the latch holds.

In burst mode, an access opens on a processor-bus address phase. The block also emits one advance pulse for each data beat after the first, up to the end of the burst. It raises the strobe once more when a write in progress has to be cancelled. In asynchronous mode, an access opens on a data-access start pulse. In both modes a completion pulse ends the access. A busy flag shows that an access is open. The mode pin is taken in only while the block is idle, so a mode change made during an access applies only to the next access. All inputs are plain single-cycle control pulses. There is no data stream and no back-pressure.

Top module: `l2s_strobe_ctrl`

## Requirements
- R1: After reset, strobe_o, burst_adv_o and busy_o are all low, and the internal beat count is zero.
- R2: In burst mode (mode_async_i=0), when the block is idle, an addr_phase_i pulse sets strobe_o high for exactly the next cycle and sets busy_o from the next cycle on. acc_start_i has no effect in this mode.
- R3: In burst mode, while busy, the first beat_i pulse gives no advance. Beats 2 to BURST_LEN (2 to 4 by default) each give a one-cycle burst_adv_o pulse in the cycle after the beat. Any later beats give none. strobe_o stays low during all of them.
- R4: In burst mode, wr_abort_i while busy raises strobe_o for one cycle and clears busy_o, both in the next cycle.
- R5: In burst mode, wr_abort_i in the same cycle as an idle addr_phase_i gives a single one-cycle strobe pulse, and busy_o stays low.
- R6: In asynchronous mode (mode_async_i=1), when the block is idle, an acc_start_i pulse sets strobe_o high for exactly the next cycle and sets busy_o. In this mode, addr_phase_i, wr_abort_i and beat_i have no effect on any output.
- R7: When busy_o is high and no abort is accepted, acc_done_i clears busy_o in the next cycle. A beat that arrives in the same cycle as acc_done_i is ignored.
- R8: The mode is latched only while the block is idle. A mode_async_i change during an access leaves that access in its original mode until completion.
- R9: When the block is idle, a wr_abort_i pulse with no address phase, or an acc_done_i pulse, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_async_i | input | 1 | 0 = burst SRAM, 1 = asynchronous SRAM with external latch |
| addr_phase_i | input | 1 | Processor-bus address phase pulse |
| acc_start_i | input | 1 | Data SRAM access start pulse |
| acc_done_i | input | 1 | Data access completion pulse |
| wr_abort_i | input | 1 | Write-abort request |
| beat_i | input | 1 | Data beat transferred |
| strobe_o | output | 1 | Registered strobe / latch enable, active high |
| burst_adv_o | output | 1 | Burst advance pulse |
| busy_o | output | 1 | Access open |

## Verification
The bench builds the block with the default BURST_LEN of 4. At this length the full beat range from zero to one past the burst end is small enough to sweep, both with and without idle gaps between beats. The abort is tried after every possible beat count. Each mode is driven with the other mode's trigger pulses to confirm they are ignored. A mid-access mode flip is tried in both directions.

// File: rtl/l2s_pkg.sv
package l2s_pkg;
  typedef struct packed {
    logic open_burst;
    logic open_async;
    logic abort;
    logic close;
  } l2s_ev_t;
endpackage

// File: rtl/l2s_event_decode.sv
module l2s_event_decode
  import l2s_pkg::*;
(
  input  logic    busy_q,
  input  logic    mode_lat,
  input  logic    mode_in,
  input  logic    addr_phase,
  input  logic    acc_start,
  input  logic    acc_done,
  input  logic    wr_abort,
  output logic    mode_eff,
  output l2s_ev_t ev
);
  always_comb begin
    mode_eff      = busy_q ? mode_lat : mode_in;
    ev.open_burst = !busy_q && !mode_eff && addr_phase;
    ev.open_async = !busy_q &&  mode_eff && acc_start;
    ev.abort      = !mode_eff && wr_abort && (busy_q || addr_phase);
    ev.close      = busy_q && acc_done;
  end
endmodule

// File: rtl/l2s_mode_busy.sv
module l2s_mode_busy
  import l2s_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mode_in,
  input  l2s_ev_t ev,
  output logic    busy_q,
  output logic    mode_lat
);
  logic busy_d;

  always_comb begin
    busy_d = busy_q;
    if (ev.abort)                          busy_d = 1'b0;
    else if (ev.open_burst || ev.open_async) busy_d = 1'b1;
    else if (ev.close)                     busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      mode_lat <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (!busy_q) mode_lat <= mode_in;
    end
  end
endmodule

// File: rtl/l2s_beat_ctr.sv
module l2s_beat_ctr
  import l2s_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    busy_q,
  input  logic    mode_lat,
  input  logic    beat,
  input  l2s_ev_t ev,
  output logic    adv_q
);
  localparam int CW = $clog2(BURST_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(BURST_LEN);

  logic [CW-1:0] cnt_q;
  logic          step;

  assign step = busy_q && !mode_lat && beat && !ev.abort && !ev.close;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      adv_q <= 1'b0;
    end else begin
      adv_q <= step && (cnt_q != '0) && (cnt_q < LAST);
      if (!busy_q || ev.abort || ev.close) cnt_q <= '0;
      else if (step && cnt_q != LAST)      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/l2s_strobe_ctrl.sv
module l2s_strobe_ctrl
  import l2s_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_async_i,
  input  logic addr_phase_i,
  input  logic acc_start_i,
  input  logic acc_done_i,
  input  logic wr_abort_i,
  input  logic beat_i,
  output logic strobe_o,
  output logic burst_adv_o,
  output logic busy_o
);
  l2s_ev_t ev;
  logic    busy_q;
  logic    mode_lat;
  logic    mode_eff;
  logic    strobe_q;

  l2s_event_decode u_dec (
    .busy_q    (busy_q),
    .mode_lat  (mode_lat),
    .mode_in   (mode_async_i),
    .addr_phase(addr_phase_i),
    .acc_start (acc_start_i),
    .acc_done  (acc_done_i),
    .wr_abort  (wr_abort_i),
    .mode_eff  (mode_eff),
    .ev        (ev)
  );

  l2s_mode_busy u_mb (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_in (mode_async_i),
    .ev      (ev),
    .busy_q  (busy_q),
    .mode_lat(mode_lat)
  );

  l2s_beat_ctr #(.BURST_LEN(BURST_LEN)) u_beat (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_q  (busy_q),
    .mode_lat(mode_lat),
    .beat    (beat_i),
    .ev      (ev),
    .adv_q   (burst_adv_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= ev.open_burst || ev.open_async || ev.abort;
  end

  assign strobe_o = strobe_q;
  assign busy_o   = busy_q;
endmodule

// File: rtl/l2s_strobe_checker.sv
module l2s_strobe_checker (
  input logic clk,
  input logic rst_n,
  input logic mode_async_i,
  input logic addr_phase_i,
  input logic acc_start_i,
  input logic acc_done_i,
  input logic wr_abort_i,
  input logic mode_lat,
  input logic strobe_o,
  input logic burst_adv_o,
  input logic busy_o
);
  assert_burst_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !mode_async_i && addr_phase_i && !wr_abort_i) |=> (strobe_o && busy_o));

  assert_adv_strobe_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_adv_o |-> (!strobe_o && busy_o));

  assert_abort_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !mode_lat && wr_abort_i) |=> (strobe_o && !busy_o));

  assert_abort_with_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !mode_async_i && addr_phase_i && wr_abort_i) |=> (strobe_o && !busy_o));

  assert_async_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && mode_async_i && acc_start_i) |=> (strobe_o && busy_o));

  assert_async_no_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_lat) |=> !burst_adv_o);

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && acc_done_i) |=> !busy_o);

  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(mode_lat));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !addr_phase_i && !acc_start_i) |=> (!strobe_o && !busy_o));
endmodule

bind l2s_strobe_ctrl l2s_strobe_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_async_i(mode_async_i),
  .addr_phase_i(addr_phase_i),
  .acc_start_i (acc_start_i),
  .acc_done_i  (acc_done_i),
  .wr_abort_i  (wr_abort_i),
  .mode_lat    (mode_lat),
  .strobe_o    (strobe_o),
  .burst_adv_o (burst_adv_o),
  .busy_o      (busy_o)
);

// File: tb/test_l2s_strobe_ctrl.sv
module test_l2s_strobe_ctrl;
  localparam int BL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, ap = 1'b0, st = 1'b0, dn = 1'b0, ab = 1'b0, bt = 1'b0;
  logic strobe, adv, busy;
  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  l2s_strobe_ctrl #(.BURST_LEN(BL)) i_l2s_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_async_i(mode),
    .addr_phase_i(ap), .acc_start_i(st), .acc_done_i(dn),
    .wr_abort_i(ab), .beat_i(bt),
    .strobe_o(strobe), .burst_adv_o(adv), .busy_o(busy)
  );

  task automatic chk(input string req, input logic s, input logic a, input logic b);
    checks++;
    if (strobe !== s || adv !== a || busy !== b) begin
      errors++;
      $display("FAIL %s: strobe/adv/busy = %b%b%b expected %b%b%b", req, strobe, adv, busy, s, a, b);
    end
  endtask

  // drive one cycle of pulses at negedge, return at the next negedge with inputs cleared
  task automatic cyc(input logic a_p, input logic s_t, input logic d_n, input logic a_b, input logic b_t);
    ap = a_p; st = s_t; dn = d_n; ab = a_b; bt = b_t;
    @(posedge clk);
    @(negedge clk);
    ap = 0; st = 0; dn = 0; ab = 0; bt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 0, 0, 0);

    // R9: idle abort or done ignored
    cyc(0, 0, 0, 1, 0); chk("R9 idle abort", 0, 0, 0);
    cyc(0, 0, 1, 0, 0); chk("R9 idle done", 0, 0, 0);
    // R2: acc_start ignored in burst mode
    cyc(0, 1, 0, 0, 0); chk("R2 start ignored", 0, 0, 0);

    // R2/R3/R7: beat-count sweep with gaps
    for (int nb = 0; nb <= BL + 1; nb++) begin
      for (int gap = 0; gap <= 1; gap++) begin
        cyc(1, 0, 0, 0, 0); chk("R2 open", 1, 0, 1);
        cyc(0, 0, 0, 0, 0); chk("R2 one-cycle strobe", 0, 0, 1);
        for (int i = 0; i < nb; i++) begin
          cyc(0, 0, 0, 0, 1);
          chk("R3 beat", 0, (i >= 1 && i < BL), 1);
          for (int g = 0; g < gap; g++) begin
            cyc(0, 0, 0, 0, 0); chk("R3 gap", 0, 0, 1);
          end
        end
        cyc(0, 0, 1, 0, 1); chk("R7 done with beat", 0, 0, 0);
      end
    end

    // R4: abort after each beat count
    for (int k = 0; k <= BL; k++) begin
      cyc(1, 0, 0, 0, 0); chk("R4 open", 1, 0, 1);
      for (int i = 0; i < k; i++) begin
        cyc(0, 0, 0, 0, 1); chk("R4 beat", 0, (i >= 1 && i < BL), 1);
      end
      cyc(0, 0, 0, 1, 0); chk("R4 abort", 1, 0, 0);
      cyc(0, 0, 0, 0, 0); chk("R4 after abort", 0, 0, 0);
    end

    // R5: abort together with address phase
    cyc(1, 0, 0, 1, 0); chk("R5 single pulse", 1, 0, 0);
    cyc(0, 0, 0, 0, 0); chk("R5 quiet", 0, 0, 0);

    // R6: asynchronous mode
    mode = 1'b1;
    cyc(1, 0, 0, 1, 0); chk("R6 addr/abort ignored idle", 0, 0, 0);
    cyc(0, 1, 0, 0, 0); chk("R6 open", 1, 0, 1);
    cyc(0, 0, 0, 0, 0); chk("R6 one-cycle strobe", 0, 0, 1);
    cyc(0, 0, 0, 1, 0); chk("R6 abort ignored", 0, 0, 1);
    cyc(1, 0, 0, 0, 0); chk("R6 addr ignored", 0, 0, 1);
    for (int i = 0; i < BL; i++) begin
      cyc(0, 0, 0, 0, 1); chk("R6 beat no adv", 0, 0, 1);
    end
    cyc(0, 0, 1, 0, 0); chk("R7 async done", 0, 0, 0);

    // R8: burst access, mode flipped to async mid-access
    mode = 1'b0;
    cyc(1, 0, 0, 0, 0); chk("R8 burst open", 1, 0, 1);
    mode = 1'b1;
    cyc(0, 1, 0, 0, 0); chk("R8 start ignored", 0, 0, 1);
    cyc(0, 0, 0, 0, 1); chk("R8 beat1", 0, 0, 1);
    cyc(0, 0, 0, 0, 1); chk("R8 beat2 still burst", 0, 1, 1);
    cyc(0, 0, 0, 1, 0); chk("R8 abort still burst", 1, 0, 0);
    cyc(0, 1, 0, 0, 0); chk("R8 new mode applies", 1, 0, 1);
    mode = 1'b0;
    cyc(0, 0, 0, 1, 0); chk("R8 async abort ignored", 0, 0, 1);
    cyc(0, 0, 0, 0, 1); chk("R8 async beat", 0, 0, 1);
    cyc(0, 0, 0, 0, 1); chk("R8 async beat2", 0, 0, 1);
    cyc(0, 0, 1, 0, 0); chk("R8 async done", 0, 0, 0);
    cyc(1, 0, 0, 0, 0); chk("R8 burst again", 1, 0, 1);
    cyc(0, 0, 1, 0, 0); chk("R7 close", 0, 0, 0);

    // R1: reset mid-access
    cyc(1, 0, 0, 0, 0);
    rst_n = 1'b0;
    #1 chk("R1 async reset", 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(1, 0, 0, 0, 0); chk("R1 counter cleared open", 1, 0, 1);
    cyc(0, 0, 0, 0, 1); chk("R1 first beat no adv", 0, 0, 1);
    cyc(0, 0, 1, 0, 0); chk("R7 final close", 0, 0, 0);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule